// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block drives the start-up staircase for the feedback reference clamp of a switching controller. A start request launches the staircase. That request may come after power-on, after recovery from a low-mains condition, or at the end of an overload restart delay. The block then presents a step code that rises through four ramp levels. Each level lasts one fixed interval. After the last level the block releases the reference to its full value. The analog side maps code 0 to 1.8 V and adds 0.55 V per code. Code 4 therefore stands for the full 4.0 V reference. With the default interval of four milliseconds at 100 MHz, the whole ramp takes sixteen milliseconds.

The block also produces a mask that holds overload protection off until the ramp has finished. It produces an enable that tells the driver whether switching is permitted. An abort input returns the block to idle at once. Abort is raised for a latch-off fault or a supply undervoltage. In idle the code sits at the first-step level and switching is blocked. A fresh start is then needed to ramp again.

Top module: `ss_ramp_seq`

## Requirements
- R1: After reset the block is idle: `ref_step_o` = 0, `ramp_active_o` = 0, `olp_mask_o` = 1, `sw_allow_o` = 0.
- R2: A start pulse sampled on a clock edge, with abort low, puts the block into the ramp on that edge: `ref_step_o` = 0, `ramp_active_o` = 1, `sw_allow_o` = 1.
- R3: During the ramp the code holds each value 0, 1, 2, 3 for exactly STEP_CYCLES clock edges, then advances by one.
- R4: After the fourth level has been held for STEP_CYCLES cycles, the block is released: `ref_step_o` = 4, `ramp_active_o` = 0, `olp_mask_o` = 0, `sw_allow_o` = 1. It holds this state until a start or an abort arrives.
- R5: `olp_mask_o` is 1 whenever the block is not released, and in particular throughout the ramp.
- R6: A start pulse during the ramp restarts it from code 0, with the first level held for a full STEP_CYCLES.
- R7: A start pulse while released re-runs the whole ramp and reasserts the mask.
- R8: Abort returns the block to the R1 idle values on the edge it is sampled. Abort takes priority over a start pulse on the same edge.
- R9: After an abort the block stays idle until a start pulse arrives. A start then runs the full ramp from code 0.
- R10: `ref_step_o` never exceeds 4. Within a ramp, with no start and no abort, it only holds or rises by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse, one cycle |
| abort_i | input | 1 | Abort to idle (latch-off or supply undervoltage) |
| ref_step_o | output | CODE_W (3) | Reference step code: 0..3 during the ramp, 4 when released |
| ramp_active_o | output | 1 | High while the ramp runs |
| olp_mask_o | output | 1 | High while overload protection must stay disabled |
| sw_allow_o | output | 1 | High when switching is permitted |

## Verification
Suppose the interval timer or the step index held a wrong value. The first symptom at the ports would be a code change one or more edges early or late. The bench samples every cycle of a ramp, so a timing slip of a single edge is caught at the step boundary where it happens. A wrong state register shows up at once. It appears as an active flag, mask or switching enable that disagrees with the code, or as an abort or restart that does not land on the edge after the request.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
   typedef enum logic [1:0] {
      SS_IDLE = 2'd0,
      SS_RAMP = 2'd1,
      SS_DONE = 2'd2
   } ss_state_e;
endpackage

// File: rtl/ss_step_timer.sv
// Counts clock cycles inside one ramp level and flags the last one.
module ss_step_timer #(
   parameter int STEP_CYCLES = 400000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic last_o
);
   localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

   initial begin
      if (STEP_CYCLES < 1) $error("STEP_CYCLES must be at least 1");
   end

   generate
      if (STEP_CYCLES == 1) begin : g_single
         // Every cycle of a level is its last one.
         assign last_o = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         assign last_o = (cnt_q == CNT_W'(STEP_CYCLES - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cnt_q <= '0;
            else if (clr_i || !run_i || last_o) cnt_q <= '0;
            else                                cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ss_step_index.sv
// Holds the current ramp level and advances it on each level end.
module ss_step_index #(
   parameter int NUM_STEPS = 4,
   parameter int IDX_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             final_o
);
   initial begin
      if (NUM_STEPS < 2)            $error("NUM_STEPS must be at least 2");
      if ((1 << IDX_W) < NUM_STEPS) $error("IDX_W too narrow for NUM_STEPS");
   end

   logic [IDX_W-1:0] idx_q;
   assign idx_o   = idx_q;
   assign final_o = (idx_q == IDX_W'(NUM_STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 idx_q <= '0;
      else if (clr_i)             idx_q <= '0;
      else if (adv_i && !final_o) idx_q <= idx_q + 1'b1;
   end
endmodule

// File: rtl/ss_ramp_seq.sv
// Stepped soft-start sequencer: staircase reference code plus protection mask.
module ss_ramp_seq #(
   parameter int STEP_CYCLES = 400000,
   parameter int NUM_STEPS   = 4,
   parameter int CODE_W      = $clog2(NUM_STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   output logic [CODE_W-1:0] ref_step_o,
   output logic              ramp_active_o,
   output logic              olp_mask_o,
   output logic              sw_allow_o
);
   import ss_seq_pkg::*;

   localparam int IDX_W = $clog2(NUM_STEPS);

   initial begin
      if ((1 << CODE_W) <= NUM_STEPS) $error("CODE_W cannot encode the release code");
   end

   ss_state_e        state_q;
   logic             restart;
   logic             in_ramp;
   logic             lvl_end;
   logic             lvl_final;
   logic [IDX_W-1:0] idx;

   assign restart = start_i | abort_i;
   assign in_ramp = (state_q == SS_RAMP);

   ss_step_timer #(.STEP_CYCLES(STEP_CYCLES)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (restart),
      .run_i  (in_ramp),
      .last_o (lvl_end)
   );

   ss_step_index #(.NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W)) i_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (restart),
      .adv_i   (in_ramp && lvl_end),
      .idx_o   (idx),
      .final_o (lvl_final)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              state_q <= SS_IDLE;
      else if (abort_i)                        state_q <= SS_IDLE;
      else if (start_i)                        state_q <= SS_RAMP;
      else if (in_ramp && lvl_end && lvl_final) state_q <= SS_DONE;
   end

   always_comb begin
      ref_step_o    = (state_q == SS_DONE) ? CODE_W'(NUM_STEPS) : CODE_W'(idx);
      ramp_active_o = in_ramp;
      olp_mask_o    = (state_q != SS_DONE);
      sw_allow_o    = (state_q != SS_IDLE);
   end
endmodule

// File: rtl/ss_ramp_seq_chk.sv
module ss_ramp_seq_chk #(
   parameter int NUM_STEPS = 4,
   parameter int CODE_W    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              abort_i,
   input logic [CODE_W-1:0] ref_step_o,
   input logic              ramp_active_o,
   input logic              olp_mask_o,
   input logic              sw_allow_o
);
   p_start_step0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !abort_i) |=> (ref_step_o == '0 && ramp_active_o && sw_allow_o));

   p_step_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_active_o && !start_i && !abort_i) |=>
      (ref_step_o == $past(ref_step_o) || ref_step_o == $past(ref_step_o) + 1'b1));

   p_release_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_step_o == CODE_W'(NUM_STEPS)) |-> (!ramp_active_o && !olp_mask_o && sw_allow_o));

   p_release_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_step_o == CODE_W'(NUM_STEPS) && !start_i && !abort_i) |=>
      (ref_step_o == CODE_W'(NUM_STEPS)));

   p_mask_ramp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_active_o |-> olp_mask_o);

   p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (ref_step_o == '0 && !ramp_active_o && !sw_allow_o && olp_mask_o));

   p_code_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ref_step_o <= CODE_W'(NUM_STEPS));
endmodule

bind ss_ramp_seq ss_ramp_seq_chk #(.NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .abort_i       (abort_i),
   .ref_step_o    (ref_step_o),
   .ramp_active_o (ramp_active_o),
   .olp_mask_o    (olp_mask_o),
   .sw_allow_o    (sw_allow_o)
);

// File: tb/test_ss_ramp_seq.sv
module test_ss_ramp_seq;
   localparam int STEP  = 5;
   localparam int NSTEP = 4;
   localparam int RAMP  = STEP * NSTEP;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       abort_i = 1'b0;
   logic [2:0] ref_step_o;
   logic       ramp_active_o, olp_mask_o, sw_allow_o;
   int         n_chk = 0;
   int         n_bad = 0;

   always #5 clk = ~clk;

   ss_ramp_seq #(.STEP_CYCLES(STEP), .NUM_STEPS(NSTEP)) i_ss_ramp_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .ref_step_o(ref_step_o), .ramp_active_o(ramp_active_o),
      .olp_mask_o(olp_mask_o), .sw_allow_o(sw_allow_o)
   );

   task automatic expect_out(string req, int code, bit act, bit msk, bit alw);
      n_chk++;
      if (ref_step_o !== 3'(code) || ramp_active_o !== act ||
          olp_mask_o !== msk || sw_allow_o !== alw) begin
         n_bad++;
         $display("FAIL %s: got code=%0d act=%b mask=%b allow=%b, exp code=%0d act=%b mask=%b allow=%b",
                  req, ref_step_o, ramp_active_o, olp_mask_o, sw_allow_o, code, act, msk, alw);
      end
   endtask

   // Expected outputs for sample i counted from the edge that took the start.
   task automatic expect_ramp_idx(string req, int i);
      if (i < RAMP) expect_out(req, i / STEP, 1'b1, 1'b1, 1'b1);
      else          expect_out(req, NSTEP, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic pulse(bit s, bit a);
      start_i = s; abort_i = a;
      @(negedge clk);
      start_i = 1'b0; abort_i = 1'b0;
   endtask

   task automatic walk(string req, int from, int n);
      for (int i = 0; i < n; i++) begin
         expect_ramp_idx(req, from + i);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      expect_out("R1", 0, 1'b0, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      expect_out("R1", 0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_full_ramp();
      pulse(1'b1, 1'b0);
      expect_out("R2", 0, 1'b1, 1'b1, 1'b1);
      walk("R3", 0, RAMP);
      walk("R4", RAMP, 6);
   endtask

   task automatic t_restart_mid();
      pulse(1'b1, 1'b0);
      walk("R5", 0, 12);
      pulse(1'b1, 1'b0);
      walk("R6", 0, RAMP + 2);
   endtask

   task automatic t_rerun_released();
      pulse(1'b1, 1'b0);
      expect_out("R7", 0, 1'b1, 1'b1, 1'b1);
      walk("R7", 0, RAMP + 2);
   endtask

   task automatic t_abort();
      pulse(1'b1, 1'b0);
      walk("R10", 0, 8);
      pulse(1'b0, 1'b1);
      expect_out("R8", 0, 1'b0, 1'b1, 1'b0);
      repeat (2 * STEP) @(negedge clk);
      expect_out("R9", 0, 1'b0, 1'b1, 1'b0);
      pulse(1'b1, 1'b1);
      expect_out("R8", 0, 1'b0, 1'b1, 1'b0);
      repeat (STEP) @(negedge clk);
      expect_out("R8", 0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_start_after_abort();
      pulse(1'b1, 1'b0);
      walk("R9", 0, RAMP + 2);
      pulse(1'b0, 1'b1);
      expect_out("R8", 0, 1'b0, 1'b1, 1'b0);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no completion, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_ramp();
      t_restart_mid();
      t_rerun_released();
      t_abort();
      t_start_after_abort();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule